// File: doc/BRIEF.md
# Predicated Cell Activity Mask Unit

This block holds the activity mask of a linear array of processing cells: one bit per cell, where a 1 means the cell takes part in the current broadcast operation. A sequencer drives one command per clock. The commands switch every cell on, narrow the mask with a per-cell Boolean condition, move to the complementary branch of the innermost condition, and return to the mask that held before that condition. Each narrowing saves the mask it replaced and its condition vector on an internal stack. This lets conditional regions nest up to a configurable depth.

Two associative commands also narrow the mask. They compare a broadcast scalar with the data word that each cell presents. The plain match keeps the active cells whose word equals the scalar. The chained match keeps a cell only when its word equals the scalar and its lower-index neighbour was active. This lets a sequencer step a marker along the array one match at a time.

A command that would overflow or underflow the stack changes nothing and raises a sticky fault output. The output is registered, so every command shows its effect one cycle after it is presented.

Top module: `pred_mask_unit`

## Requirements
- R1: While `rst` is high and after its release, `active_o` is all ones and `error_o` is 0, with the stack empty.
- R2: Command code 1 (all-on) sets every bit of `active_o` to 1 and leaves the stack contents and level untouched.
- R3: Command code 2 (narrow), with the stack below its depth, pushes the current mask and `cond_i`, and the new mask is the old mask AND `cond_i`.
- R4: Command code 3 (invert branch), with the stack non-empty, sets the mask to the saved mask of the top entry AND NOT its saved condition. The stack is unchanged.
- R5: Command code 4 (restore), with the stack non-empty, sets the mask to the saved mask of the top entry and pops it. Nested levels restore in reverse order.
- R6: Command code 5 (match) keeps bit i set only if it was set and cell word i equals `scalar_i`. Cell word i occupies bits [i*DATA_W +: DATA_W] of `cell_data_i`.
- R7: Command code 6 (chained match) sets bit i (i>0) to 1 exactly when bit i-1 was set and cell word i equals `scalar_i`. Bit 0 always becomes 0.
- R8: A narrow with the stack full, or an invert or restore with the stack empty, leaves the mask and stack unchanged and sets `error_o`.
- R9: `error_o` stays 1 until reset, and later commands still execute normally.
- R10: Command codes 0 and 7 leave the mask and stack unchanged.
- R11: A command's effect is not visible on `active_o` before the clock edge that accepts it, and is visible right after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 3 | Command code |
| cond_i | input | CELLS | Per-cell condition vector |
| scalar_i | input | DATA_W | Broadcast comparison value |
| cell_data_i | input | CELLS*DATA_W | Packed per-cell data words, cell 0 in the low bits |
| active_o | output | CELLS | Current per-cell activity mask |
| error_o | output | 1 | Sticky stack overflow/underflow fault |

## Verification
A narrow issued at full stack depth puts a push request and a fault into the same cycle. So does a restore or invert issued with the stack empty. The bench fills the stack with distinct conditions and then issues one more narrow. In separate runs it issues a restore and an invert on an empty stack. In each case it judges that the mask holds its prior value while the fault rises. It then unwinds the stack and checks that every saved level returns intact, which shows that the rejected push wrote nothing.

// File: rtl/pmask_pkg.sv
package pmask_pkg;

    typedef enum logic [2:0] {
        CMD_IDLE    = 3'd0,
        CMD_ALL     = 3'd1,
        CMD_NARROW  = 3'd2,
        CMD_INVERT  = 3'd3,
        CMD_RESTORE = 3'd4,
        CMD_MATCH   = 3'd5,
        CMD_CHAIN   = 3'd6,
        CMD_SPARE   = 3'd7
    } pm_cmd_e;

    typedef struct packed {
        logic push;
        logic pop;
        logic fault;
    } pm_ctl_t;

    function automatic pm_cmd_e pm_decode(input logic [2:0] raw);
        return pm_cmd_e'(raw);
    endfunction

endpackage

// File: rtl/pmask_stack.sv
module pmask_stack #(
    parameter int CELLS = 8,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  logic [CELLS-1:0] push_mask,
    input  logic [CELLS-1:0] push_cond,
    output logic [CELLS-1:0] top_mask,
    output logic [CELLS-1:0] top_cond,
    output logic             full,
    output logic             empty
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [CELLS-1:0] mem_mask [DEPTH];
    logic [CELLS-1:0] mem_cond [DEPTH];
    logic [CNT_W-1:0] level;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] top_idx;

    assign full    = (level == CNT_W'(DEPTH));
    assign empty   = (level == '0);
    assign wr_idx  = IDX_W'(level);
    assign top_idx = empty ? '0 : IDX_W'(level - 1'b1);

    assign top_mask = mem_mask[top_idx];
    assign top_cond = mem_cond[top_idx];

    always_ff @(posedge clk) begin
        if (push && !full) begin
            mem_mask[wr_idx] <= push_mask;
            mem_cond[wr_idx] <= push_cond;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level <= '0;
        end else if (push && !full) begin
            level <= level + 1'b1;
        end else if (pop && !empty) begin
            level <= level - 1'b1;
        end
    end

endmodule

// File: rtl/pmask_match.sv
module pmask_match #(
    parameter int CELLS  = 8,
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0]       scalar_i,
    input  logic [CELLS*DATA_W-1:0] cell_data_i,
    output logic [CELLS-1:0]        hit_o
);
    for (genvar c = 0; c < CELLS; c++) begin : g_cell
        assign hit_o[c] = (cell_data_i[c*DATA_W +: DATA_W] == scalar_i);
    end

endmodule

// File: rtl/pmask_next.sv
module pmask_next
    import pmask_pkg::*;
#(
    parameter int CELLS = 8
) (
    input  logic [2:0]       cmd_i,
    input  logic [CELLS-1:0] cond_i,
    input  logic [CELLS-1:0] hit_i,
    input  logic [CELLS-1:0] cur_mask,
    input  logic [CELLS-1:0] top_mask,
    input  logic [CELLS-1:0] top_cond,
    input  logic             full,
    input  logic             empty,
    output logic [CELLS-1:0] nxt_mask,
    output pm_ctl_t          ctl
);
    logic [CELLS-1:0] chain_mask;

    assign chain_mask = {hit_i[CELLS-1:1] & cur_mask[CELLS-2:0], 1'b0};

    always_comb begin
        nxt_mask = cur_mask;
        ctl      = '0;
        case (pm_decode(cmd_i))
            CMD_ALL: nxt_mask = '1;
            CMD_NARROW: begin
                if (full) begin
                    ctl.fault = 1'b1;
                end else begin
                    ctl.push = 1'b1;
                    nxt_mask = cur_mask & cond_i;
                end
            end
            CMD_INVERT: begin
                if (empty) ctl.fault = 1'b1;
                else       nxt_mask  = top_mask & ~top_cond;
            end
            CMD_RESTORE: begin
                if (empty) begin
                    ctl.fault = 1'b1;
                end else begin
                    ctl.pop  = 1'b1;
                    nxt_mask = top_mask;
                end
            end
            CMD_MATCH: nxt_mask = cur_mask & hit_i;
            CMD_CHAIN: nxt_mask = chain_mask;
            default:   nxt_mask = cur_mask;
        endcase
    end

endmodule

// File: rtl/pred_mask_unit.sv
module pred_mask_unit
    import pmask_pkg::*;
#(
    parameter int CELLS  = 8,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [2:0]              cmd_i,
    input  logic [CELLS-1:0]        cond_i,
    input  logic [DATA_W-1:0]       scalar_i,
    input  logic [CELLS*DATA_W-1:0] cell_data_i,
    output logic [CELLS-1:0]        active_o,
    output logic                    error_o
);
    logic [CELLS-1:0] mask_q;
    logic [CELLS-1:0] mask_d;
    logic [CELLS-1:0] hit;
    logic [CELLS-1:0] top_mask;
    logic [CELLS-1:0] top_cond;
    logic             stk_full;
    logic             stk_empty;
    logic             err_q;
    pm_ctl_t          ctl;

    pmask_match #(.CELLS(CELLS), .DATA_W(DATA_W)) u_match (
        .scalar_i    (scalar_i),
        .cell_data_i (cell_data_i),
        .hit_o       (hit)
    );

    pmask_stack #(.CELLS(CELLS), .DEPTH(DEPTH)) u_stack (
        .clk       (clk),
        .rst       (rst),
        .push      (ctl.push),
        .pop       (ctl.pop),
        .push_mask (mask_q),
        .push_cond (cond_i),
        .top_mask  (top_mask),
        .top_cond  (top_cond),
        .full      (stk_full),
        .empty     (stk_empty)
    );

    pmask_next #(.CELLS(CELLS)) u_next (
        .cmd_i    (cmd_i),
        .cond_i   (cond_i),
        .hit_i    (hit),
        .cur_mask (mask_q),
        .top_mask (top_mask),
        .top_cond (top_cond),
        .full     (stk_full),
        .empty    (stk_empty),
        .nxt_mask (mask_d),
        .ctl      (ctl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
            err_q  <= 1'b0;
        end else begin
            mask_q <= mask_d;
            err_q  <= err_q | ctl.fault;
        end
    end

    assign active_o = mask_q;
    assign error_o  = err_q;

endmodule

// File: rtl/pmask_checker.sv
module pmask_checker
    import pmask_pkg::*;
#(
    parameter int CELLS = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [2:0]       cmd_i,
    input logic [CELLS-1:0] cond_i,
    input logic [CELLS-1:0] active_o,
    input logic             error_o,
    input logic             stk_full,
    input logic             stk_empty
);
    AST_ALL_ON: assert property (@(posedge clk) disable iff (rst)
        cmd_i == CMD_ALL |=> active_o == '1); // R2

    AST_NARROW_AND: assert property (@(posedge clk) disable iff (rst)
        (cmd_i == CMD_NARROW && !stk_full) |=> active_o == ($past(active_o) & $past(cond_i))); // R3

    AST_MATCH_SUBSET: assert property (@(posedge clk) disable iff (rst)
        cmd_i == CMD_MATCH |=> (active_o & ~$past(active_o)) == '0); // R6

    AST_CHAIN_CELL0: assert property (@(posedge clk) disable iff (rst)
        cmd_i == CMD_CHAIN |=> !active_o[0]); // R7

    AST_OVERFLOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cmd_i == CMD_NARROW && stk_full) |=> ($stable(active_o) && error_o)); // R8

    AST_UNDERFLOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        ((cmd_i == CMD_RESTORE || cmd_i == CMD_INVERT) && stk_empty) |=> ($stable(active_o) && error_o)); // R8

    AST_ERROR_STICKY: assert property (@(posedge clk) disable iff (rst)
        error_o |=> error_o); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cmd_i == CMD_IDLE || cmd_i == CMD_SPARE) |=> $stable(active_o)); // R10

endmodule

bind pred_mask_unit pmask_checker #(.CELLS(CELLS)) u_pmask_checker (
    .clk       (clk),
    .rst       (rst),
    .cmd_i     (cmd_i),
    .cond_i    (cond_i),
    .active_o  (active_o),
    .error_o   (error_o),
    .stk_full  (stk_full),
    .stk_empty (stk_empty)
);

// File: tb/test_pred_mask_unit.sv
module test_pred_mask_unit;
    localparam int PERIOD = 10;
    localparam int N = 8;
    localparam int W = 4;
    localparam int D = 4;

    logic           clk = 1'b0;
    logic           rst;
    logic [2:0]     cmd;
    logic [N-1:0]   cond;
    logic [W-1:0]   scal;
    logic [N*W-1:0] data;
    logic [N-1:0]   act;
    logic           err;

    logic [N-1:0] m_mask;
    logic         m_err;
    logic [N-1:0] s_mask [D];
    logic [N-1:0] s_cond [D];
    int           m_lvl;
    int           n_chk = 0;
    int           n_bad = 0;

    always #(PERIOD/2) clk = ~clk;

    pred_mask_unit #(.CELLS(N), .DATA_W(W), .DEPTH(D)) i_pred_mask_unit (
        .clk(clk), .rst(rst), .cmd_i(cmd), .cond_i(cond), .scalar_i(scal),
        .cell_data_i(data), .active_o(act), .error_o(err)
    );

    task automatic check(input string req, input logic [N-1:0] em, input logic ee);
        n_chk++;
        if (act !== em || err !== ee) begin
            n_bad++;
            $display("FAIL %s: mask=%b err=%b expected mask=%b err=%b", req, act, err, em, ee);
        end
    endtask

    function automatic logic [N*W-1:0] make_data(input int a, input int b, input int modv);
        logic [N*W-1:0] v;
        for (int i = 0; i < N; i++) v[i*W +: W] = W'((i * a + b) % modv);
        return v;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cmd = 3'd0; cond = '0; scal = '0; data = '0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_mask = '1; m_err = 1'b0; m_lvl = 0;
        check("R1", '1, 1'b0);
    endtask

    task automatic step(input logic [2:0] c, input logic [N-1:0] cv, input logic [W-1:0] sv,
                        input logic [N*W-1:0] dv, input string req);
        logic [N-1:0] hits;
        @(negedge clk);
        cmd = c; cond = cv; scal = sv; data = dv;
        #1 check("R11", m_mask, m_err);
        for (int i = 0; i < N; i++) hits[i] = (dv[i*W +: W] == sv);
        @(posedge clk);
        case (c)
            3'd1: m_mask = '1;
            3'd2: if (m_lvl == D) m_err = 1'b1;
                  else begin
                      s_mask[m_lvl] = m_mask; s_cond[m_lvl] = cv;
                      m_lvl++; m_mask = m_mask & cv;
                  end
            3'd3: if (m_lvl == 0) m_err = 1'b1;
                  else m_mask = s_mask[m_lvl-1] & ~s_cond[m_lvl-1];
            3'd4: if (m_lvl == 0) m_err = 1'b1;
                  else begin m_lvl--; m_mask = s_mask[m_lvl]; end
            3'd5: m_mask = m_mask & hits;
            3'd6: m_mask = {hits[N-1:1] & m_mask[N-2:0], 1'b0};
            default: ;
        endcase
        #1 check(req, m_mask, m_err);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        do_reset();

        // R3 R4 R5: every condition inside a non-trivial enclosing branch
        step(3'd2, 8'hA5, '0, '0, "R3");
        for (int c = 0; c < 256; c++) begin
            step(3'd2, N'(c), '0, '0, "R3");
            step(3'd3, '0, '0, '0, "R4");
            step(3'd4, '0, '0, '0, "R5");
        end
        step(3'd4, '0, '0, '0, "R5");

        // R2: all-on keeps stack contents
        step(3'd2, 8'h3C, '0, '0, "R3");
        step(3'd2, 8'h0F, '0, '0, "R3");
        step(3'd1, '0, '0, '0, "R2");
        step(3'd4, '0, '0, '0, "R2");
        step(3'd4, '0, '0, '0, "R2");

        // R10: idle and spare codes
        for (int c = 0; c < 16; c++) begin
            step(3'd2, N'(c * 37), '0, '0, "R3");
            step(3'd0, N'(c * 11), W'(c), make_data(1, c, 16), "R10");
            step(3'd7, N'(~c), W'(c), make_data(3, c, 16), "R10");
            step(3'd4, '0, '0, '0, "R5");
        end

        // R8 underflow via restore, then R9
        do_reset();
        step(3'd4, '0, '0, '0, "R8");
        step(3'd2, 8'h5A, '0, '0, "R9");
        step(3'd4, '0, '0, '0, "R9");
        step(3'd1, '0, '0, '0, "R9");
        // R8 underflow via invert
        do_reset();
        step(3'd3, 8'hFF, '0, '0, "R8");
        // R8 overflow: fill, reject, unwind
        do_reset();
        step(3'd2, 8'hFE, '0, '0, "R3");
        step(3'd2, 8'hDF, '0, '0, "R3");
        step(3'd2, 8'h7B, '0, '0, "R3");
        step(3'd2, 8'hF3, '0, '0, "R3");
        step(3'd2, 8'h00, '0, '0, "R8");
        step(3'd3, '0, '0, '0, "R4");
        for (int k = 0; k < D; k++) step(3'd4, '0, '0, '0, "R5");
        step(3'd5, '0, 4'd2, make_data(1, 0, 4), "R9");

        // R6: plain match sweep
        do_reset();
        for (int s = 0; s < 16; s++) begin
            for (int p = 0; p < 4; p++) begin
                step(3'd2, N'(8'hF7 ^ (s * 13 + p)), '0, '0, "R3");
                step(3'd5, '0, W'(s), make_data(p + 1, p, 16), "R6");
                step(3'd5, '0, W'(s), make_data(1, s, 3 + p), "R6");
                step(3'd4, '0, '0, '0, "R5");
            end
        end

        // R7: chained match over every prior mask
        for (int m = 0; m < 256; m++) begin
            step(3'd2, N'(m), '0, '0, "R3");
            step(3'd6, '0, W'(m % 3), make_data(1, m, 3), "R7");
            step(3'd6, '0, W'(0), make_data(0, 0, 2), "R7");
            step(3'd4, '0, '0, '0, "R5");
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule